// File: doc/BRIEF.md
# Dual-Issue In-Order Dispatch Controller

This block sits between a micro-op queue and the execution back end. Each cycle it looks at the two oldest queued micro-ops, called slot 0 and slot 1, and decides which of them leave the queue. Slot 0 is always older than slot 1, so slot 1 may only go when slot 0 goes in the same cycle. The hazard analysis is done elsewhere: it arrives as flags, together with each slot's execution-unit tag and its count of source-register reads.

A slot is accepted only when its whole set of destinations can take it in that cycle. That set is its reservation station, the extra mapping channel when the slot is a load-store micro-op, and the reorder buffer. Valid is raised on every one of those channels together, and the same signal is the slot's ready back to the queue. The block also gives each slot its reorder-buffer entry. Slot 0 takes the entry the buffer offers. Slot 1 takes the next entry, unless it continues a reduction or compare that already owns the current one.

The block is purely combinational. It holds no state, and every output follows from the inputs of the same cycle.

Top module: `dual_dispatch_ctrl`

## Requirements
- R1: Slot 0 is accepted exactly when it is valid, has no pending reorder-buffer hazard, carries a legal unit tag, and its unit's reservation-station ready, its reorder-buffer ready and (for a load-store tag) its map-info ready are all high.
- R2: Slot 1 is never accepted in a cycle in which slot 0 is not accepted.
- R3: A pending reorder-buffer hazard on slot 0 blocks both slots.
- R4: A pending reorder-buffer hazard on slot 1 blocks slot 1 only; slot 0 is decided as if slot 1 were absent.
- R5: When slot 1 reads the register that slot 0 writes, slot 1 is held back and slot 0 is unaffected.
- R6: When the source-read counts of the two slots add up to more than READ_BUDGET (default 4), only slot 0 can be accepted. A total of exactly READ_BUDGET does not block.
- R7: Unit tags are encoded as ALU=0, permute/reduction=1, multiply=2, divide=3, load-store=4. An accepted slot raises exactly the one reservation-station valid that its tag selects. A slot that is not accepted raises none. Tags 5 to 7 are never accepted.
- R8: An accepted load-store slot also raises its map-info valid. No other slot does.
- R9: A slot's queue ready and its reorder-buffer valid both equal its acceptance.
- R10: Slot 0's entry equals the allocation index. Slot 1's entry equals the allocation index when slot 1 is a reduction or compare micro-op that is not the first of its instruction. Otherwise it equals the allocation index plus one, modulo 2^ROB_AW.
- R11: With both slots invalid, every valid and ready output is low, whatever the downstream readys are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| slot_valid_i | input | 2 | Per-slot micro-op valid from the queue |
| slot_unit_i | input | 2x3 | Per-slot execution-unit tag |
| slot_nsrc_i | input | 2x3 | Per-slot count of source-register reads |
| slot_rob_raw_i | input | 2 | Per-slot hazard against an unfinished reorder-buffer entry |
| slot1_dep_i | input | 1 | Slot 1 reads slot 0's destination |
| slot1_redcmp_i | input | 1 | Slot 1 is a reduction or compare micro-op |
| slot1_first_i | input | 1 | Slot 1 is the first micro-op of its instruction |
| rs_ready_i | input | 2x5 | Per-slot, per-unit reservation-station ready |
| map_ready_i | input | 2 | Per-slot load-store map-info ready |
| rob_ready_i | input | 2 | Per-slot reorder-buffer ready |
| rob_alloc_i | input | 4 | Next free reorder-buffer entry |
| slot_ready_o | output | 2 | Per-slot ready back to the queue |
| rs_valid_o | output | 2x5 | Per-slot, per-unit reservation-station valid |
| map_valid_o | output | 2 | Per-slot load-store map-info valid |
| rob_valid_o | output | 2 | Per-slot reorder-buffer valid |
| slot_rob_idx_o | output | 2x4 | Per-slot reorder-buffer entry |

## Verification
The bench sweeps every combination of the slot valids and the three hazard flags. It covers all legal tags plus an illegal one on each slot, and read counts whose sum runs from two to six. This separates a stall caused by slot 0 from a hold on slot 1 alone, and it places the read budget exactly at its edge. Readys and the reuse flags come from a pseudo-random stream, so the same hazard pattern is seen both with stalled and with free destinations, which shows that the readys gate acceptance rather than hazards. Directed cases check the idle state and the wrap of slot 1's entry past the top index.

// File: rtl/dsp_pkg.sv
package dsp_pkg;
  localparam int NUM_SLOTS = 2;
  localparam int NUM_UNITS = 5;
  localparam int UNIT_W    = 3;

  typedef enum logic [UNIT_W-1:0] {
    UNIT_ALU = 3'd0,
    UNIT_PRD = 3'd1,
    UNIT_MUL = 3'd2,
    UNIT_DIV = 3'd3,
    UNIT_LSU = 3'd4
  } unit_e;
endpackage

// File: rtl/dsp_unit_decode.sv
module dsp_unit_decode
  import dsp_pkg::*;
(
  input  logic [UNIT_W-1:0]    unit_i,
  input  logic [NUM_UNITS-1:0] rs_ready_i,
  input  logic                 map_ready_i,
  input  logic                 rob_ready_i,
  output logic [NUM_UNITS-1:0] onehot_o,
  output logic                 is_lsu_o,
  output logic                 targets_ready_o
);
  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_dec
    assign onehot_o[u] = (unit_i == UNIT_W'(u));
  end

  assign is_lsu_o        = onehot_o[UNIT_LSU];
  // an illegal tag selects nothing, so no target is ever ready for it
  assign targets_ready_o = (|(onehot_o & rs_ready_i)) & (~is_lsu_o | map_ready_i) & rob_ready_i;
endmodule

// File: rtl/dsp_issue_gate.sv
module dsp_issue_gate #(
  parameter int READ_BUDGET = 4,
  localparam int SRC_W      = $clog2(READ_BUDGET + 1)
) (
  input  logic [1:0]            valid_i,
  input  logic [1:0]            rob_raw_i,
  input  logic                  dep_i,
  input  logic [1:0][SRC_W-1:0] nsrc_i,
  input  logic [1:0]            tgt_ready_i,
  output logic [1:0]            accept_o
);
  logic [SRC_W:0] reads_total;
  logic           fits;
  logic           s0_ok;
  logic           s1_ok;

  assign reads_total = {1'b0, nsrc_i[0]} + {1'b0, nsrc_i[1]};
  assign fits        = reads_total <= (SRC_W+1)'(READ_BUDGET);

  assign s0_ok = valid_i[0] & ~rob_raw_i[0] & tgt_ready_i[0];
  // in-order: slot 1 rides only on an accepted slot 0
  assign s1_ok = s0_ok & valid_i[1] & ~rob_raw_i[1] & ~dep_i & fits & tgt_ready_i[1];

  assign accept_o = {s1_ok, s0_ok};
endmodule

// File: rtl/dsp_rob_addr.sv
module dsp_rob_addr #(
  parameter int ROB_AW = 4
) (
  input  logic [ROB_AW-1:0]      alloc_i,
  input  logic                   redcmp_i,
  input  logic                   first_i,
  output logic [1:0][ROB_AW-1:0] idx_o
);
  logic share;

  assign share    = redcmp_i & ~first_i;
  assign idx_o[0] = alloc_i;
  assign idx_o[1] = share ? alloc_i : alloc_i + ROB_AW'(1);
endmodule

// File: rtl/dual_dispatch_ctrl.sv
module dual_dispatch_ctrl
  import dsp_pkg::*;
#(
  parameter int ROB_AW       = 4,
  parameter int READ_BUDGET  = 4,
  localparam int SRC_W       = $clog2(READ_BUDGET + 1)
) (
  input  logic [NUM_SLOTS-1:0]                slot_valid_i,
  input  logic [NUM_SLOTS-1:0][UNIT_W-1:0]    slot_unit_i,
  input  logic [NUM_SLOTS-1:0][SRC_W-1:0]     slot_nsrc_i,
  input  logic [NUM_SLOTS-1:0]                slot_rob_raw_i,
  input  logic                                slot1_dep_i,
  input  logic                                slot1_redcmp_i,
  input  logic                                slot1_first_i,
  input  logic [NUM_SLOTS-1:0][NUM_UNITS-1:0] rs_ready_i,
  input  logic [NUM_SLOTS-1:0]                map_ready_i,
  input  logic [NUM_SLOTS-1:0]                rob_ready_i,
  input  logic [ROB_AW-1:0]                   rob_alloc_i,
  output logic [NUM_SLOTS-1:0]                slot_ready_o,
  output logic [NUM_SLOTS-1:0][NUM_UNITS-1:0] rs_valid_o,
  output logic [NUM_SLOTS-1:0]                map_valid_o,
  output logic [NUM_SLOTS-1:0]                rob_valid_o,
  output logic [NUM_SLOTS-1:0][ROB_AW-1:0]    slot_rob_idx_o
);
  logic [NUM_SLOTS-1:0][NUM_UNITS-1:0] unit_oh;
  logic [NUM_SLOTS-1:0]                is_lsu;
  logic [NUM_SLOTS-1:0]                tgt_ready;
  logic [NUM_SLOTS-1:0]                accept;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    dsp_unit_decode u_dec (
      .unit_i          (slot_unit_i[s]),
      .rs_ready_i      (rs_ready_i[s]),
      .map_ready_i     (map_ready_i[s]),
      .rob_ready_i     (rob_ready_i[s]),
      .onehot_o        (unit_oh[s]),
      .is_lsu_o        (is_lsu[s]),
      .targets_ready_o (tgt_ready[s])
    );

    assign rs_valid_o[s]  = unit_oh[s] & {NUM_UNITS{accept[s]}};
    assign map_valid_o[s] = accept[s] & is_lsu[s];
  end

  dsp_issue_gate #(
    .READ_BUDGET (READ_BUDGET)
  ) u_gate (
    .valid_i     (slot_valid_i),
    .rob_raw_i   (slot_rob_raw_i),
    .dep_i       (slot1_dep_i),
    .nsrc_i      (slot_nsrc_i),
    .tgt_ready_i (tgt_ready),
    .accept_o    (accept)
  );

  dsp_rob_addr #(
    .ROB_AW (ROB_AW)
  ) u_rob_addr (
    .alloc_i  (rob_alloc_i),
    .redcmp_i (slot1_redcmp_i),
    .first_i  (slot1_first_i),
    .idx_o    (slot_rob_idx_o)
  );

  assign slot_ready_o = accept;
  assign rob_valid_o  = accept;
endmodule

// File: rtl/dual_dispatch_ctrl_chk.sv
module dual_dispatch_ctrl_chk
  import dsp_pkg::*;
#(
  parameter int ROB_AW      = 4,
  parameter int READ_BUDGET = 4,
  localparam int SRC_W      = $clog2(READ_BUDGET + 1)
) (
  input logic [NUM_SLOTS-1:0]                slot_valid_i,
  input logic [NUM_SLOTS-1:0][SRC_W-1:0]     slot_nsrc_i,
  input logic [NUM_SLOTS-1:0]                slot_rob_raw_i,
  input logic                                slot1_dep_i,
  input logic [ROB_AW-1:0]                   rob_alloc_i,
  input logic [NUM_SLOTS-1:0]                slot_ready_o,
  input logic [NUM_SLOTS-1:0][NUM_UNITS-1:0] rs_valid_o,
  input logic [NUM_SLOTS-1:0]                map_valid_o,
  input logic [NUM_SLOTS-1:0]                rob_valid_o,
  input logic [NUM_SLOTS-1:0][ROB_AW-1:0]    slot_rob_idx_o
);
  logic [SRC_W:0] reads_total;
  assign reads_total = {1'b0, slot_nsrc_i[0]} + {1'b0, slot_nsrc_i[1]};

  always_comb begin
    assert_in_order_R2: assert (!slot_ready_o[1] || slot_ready_o[0]);
    assert_raw0_stall_R3: assert (!slot_rob_raw_i[0] || slot_ready_o == '0);
    assert_raw1_hold_R4: assert (!slot_rob_raw_i[1] || !slot_ready_o[1]);
    assert_dep_hold_R5: assert (!slot1_dep_i || !slot_ready_o[1]);
    assert_read_budget_R6: assert (!slot_ready_o[1] || reads_total <= (SRC_W+1)'(READ_BUDGET));
    assert_onehot_valid_R7: assert ($countones(rs_valid_o[0]) == int'(slot_ready_o[0]) &&
                                    $countones(rs_valid_o[1]) == int'(slot_ready_o[1]));
    assert_map_lsu_R8: assert (map_valid_o[0] == (slot_ready_o[0] & rs_valid_o[0][UNIT_LSU]) &&
                               map_valid_o[1] == (slot_ready_o[1] & rs_valid_o[1][UNIT_LSU]));
    assert_rob_valid_R9: assert (rob_valid_o == slot_ready_o);
    assert_rob_idx0_R10: assert (slot_rob_idx_o[0] == rob_alloc_i);
    assert_idle_R11: assert (slot_valid_i != '0 || (slot_ready_o == '0 && map_valid_o == '0));
  end
endmodule

bind dual_dispatch_ctrl dual_dispatch_ctrl_chk #(
  .ROB_AW      (ROB_AW),
  .READ_BUDGET (READ_BUDGET)
) u_chk (
  .slot_valid_i   (slot_valid_i),
  .slot_nsrc_i    (slot_nsrc_i),
  .slot_rob_raw_i (slot_rob_raw_i),
  .slot1_dep_i    (slot1_dep_i),
  .rob_alloc_i    (rob_alloc_i),
  .slot_ready_o   (slot_ready_o),
  .rs_valid_o     (rs_valid_o),
  .map_valid_o    (map_valid_o),
  .rob_valid_o    (rob_valid_o),
  .slot_rob_idx_o (slot_rob_idx_o)
);

// File: tb/dual_dispatch_ctrl_tb.sv
module dual_dispatch_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW         = 4;
  localparam int NU         = 5;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [1:0]         slot_valid_i;
  logic [1:0][2:0]    slot_unit_i;
  logic [1:0][2:0]    slot_nsrc_i;
  logic [1:0]         slot_rob_raw_i;
  logic               slot1_dep_i;
  logic               slot1_redcmp_i;
  logic               slot1_first_i;
  logic [1:0][NU-1:0] rs_ready_i;
  logic [1:0]         map_ready_i;
  logic [1:0]         rob_ready_i;
  logic [AW-1:0]      rob_alloc_i;
  logic [1:0]         slot_ready_o;
  logic [1:0][NU-1:0] rs_valid_o;
  logic [1:0]         map_valid_o;
  logic [1:0]         rob_valid_o;
  logic [1:0][AW-1:0] slot_rob_idx_o;

  dual_dispatch_ctrl u_dut (
    .slot_valid_i   (slot_valid_i),
    .slot_unit_i    (slot_unit_i),
    .slot_nsrc_i    (slot_nsrc_i),
    .slot_rob_raw_i (slot_rob_raw_i),
    .slot1_dep_i    (slot1_dep_i),
    .slot1_redcmp_i (slot1_redcmp_i),
    .slot1_first_i  (slot1_first_i),
    .rs_ready_i     (rs_ready_i),
    .map_ready_i    (map_ready_i),
    .rob_ready_i    (rob_ready_i),
    .rob_alloc_i    (rob_alloc_i),
    .slot_ready_o   (slot_ready_o),
    .rs_valid_o     (rs_valid_o),
    .map_valid_o    (map_valid_o),
    .rob_valid_o    (rob_valid_o),
    .slot_rob_idx_o (slot_rob_idx_o)
  );

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  logic [31:0] rng = 32'h1234_5678;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] next_rng(input logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  // reference computed from the requirement text
  task automatic check_all();
    bit [1:0] tr;
    bit [1:0] acc;
    bit [1:0] lsu;
    logic [1:0][NU-1:0] exp_rs;
    logic [AW-1:0] exp_idx1;
    int sum;
    string t1;
    for (int s = 0; s < 2; s++) begin
      int u = int'(slot_unit_i[s]);
      lsu[s] = (u == 4);
      tr[s]  = (u < NU) && rs_ready_i[s][u] && rob_ready_i[s] && (!lsu[s] || map_ready_i[s]);
    end
    sum    = int'(slot_nsrc_i[0]) + int'(slot_nsrc_i[1]);
    acc[0] = slot_valid_i[0] && !slot_rob_raw_i[0] && tr[0];
    acc[1] = acc[0] && slot_valid_i[1] && !slot_rob_raw_i[1] && !slot1_dep_i && (sum <= 4) && tr[1];
    for (int s = 0; s < 2; s++) begin
      exp_rs[s] = '0;
      if (acc[s]) exp_rs[s][slot_unit_i[s]] = 1'b1;
    end
    exp_idx1 = (slot1_redcmp_i && !slot1_first_i) ? rob_alloc_i : rob_alloc_i + 1'b1;

    chk(slot_rob_raw_i[0] ? "R3 slot0 ready" : "R1 slot0 ready", 32'(slot_ready_o[0]), 32'(acc[0]));
    if (!acc[0])               t1 = "R2 slot1 ready";
    else if (slot_rob_raw_i[1]) t1 = "R4 slot1 ready";
    else if (slot1_dep_i)       t1 = "R5 slot1 ready";
    else if (sum > 4)           t1 = "R6 slot1 ready";
    else                        t1 = "R1 slot1 ready";
    chk(t1, 32'(slot_ready_o[1]), 32'(acc[1]));
    chk("R7 rs valid", 32'(rs_valid_o), 32'(exp_rs));
    chk("R8 map valid", 32'(map_valid_o), 32'(acc & lsu));
    chk("R9 rob valid", 32'(rob_valid_o), 32'(acc));
    chk("R10 slot0 idx", 32'(slot_rob_idx_o[0]), 32'(rob_alloc_i));
    chk("R10 slot1 idx", 32'(slot_rob_idx_o[1]), 32'(exp_idx1));
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    slot_valid_i = '0; slot_unit_i = '0; slot_nsrc_i = '0; slot_rob_raw_i = '0;
    slot1_dep_i = 0; slot1_redcmp_i = 0; slot1_first_i = 0;
    rs_ready_i = '1; map_ready_i = '1; rob_ready_i = '1; rob_alloc_i = '0;

    // R11 idle: nothing valid, all downstream ready
    @(posedge clk);
    @(negedge clk);
    chk("R11 idle ready", 32'(slot_ready_o), 0);
    chk("R11 idle rs", 32'(rs_valid_o), 0);
    chk("R11 idle map/rob", 32'({map_valid_o, rob_valid_o}), 0);

    // R10 wrap of slot 1 entry past the top index
    @(posedge clk);
    rob_alloc_i = '1; slot1_redcmp_i = 0; slot1_first_i = 0;
    @(negedge clk);
    chk("R10 wrap", 32'(slot_rob_idx_o[1]), 0);
    @(posedge clk);
    slot1_redcmp_i = 1; slot1_first_i = 0;
    @(negedge clk);
    chk("R10 share at top", 32'(slot_rob_idx_o[1]), 32'(AW'('1)));

    // near-exhaustive sweep
    for (int v = 0; v < 4; v++)
      for (int hz = 0; hz < 8; hz++)
        for (int u0 = 0; u0 < 6; u0++)
          for (int u1 = 0; u1 < 6; u1++)
            for (int np = 0; np < 9; np++) begin
              @(posedge clk);
              rng = next_rng(rng);
              slot_valid_i   = 2'(v);
              slot_rob_raw_i = {hz[1], hz[0]};
              slot1_dep_i    = hz[2];
              slot_unit_i[0] = 3'(u0 == 5 ? 7 : u0);
              slot_unit_i[1] = 3'(u1 == 5 ? 5 : u1);
              slot_nsrc_i[0] = 3'(np / 3 + 1);
              slot_nsrc_i[1] = 3'(np % 3 + 1);
              // readys high with probability 3/4
              rs_ready_i     = 10'(rng[9:0] | rng[19:10]);
              map_ready_i    = rng[21:20] | rng[23:22];
              rob_ready_i    = rng[25:24] | rng[27:26];
              slot1_redcmp_i = rng[28];
              slot1_first_i  = rng[29];
              rob_alloc_i    = AW'(rng[31:28] ^ rng[3:0]);
              @(negedge clk);
              check_all();
            end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule